// File: doc/BRIEF.md
# Programmable Logic Output Cell

This block is one output cell of a programmable logic array. It ORs a set of product terms that the AND plane supplies. Some of those terms are its own and some are borrowed from neighbouring cells. It can invert the resulting sum. It then either passes the sum straight to the pin or sends it through a storage element whose type is chosen at run time: D, toggle, JK or set/reset. The value that leaves the cell drives the pin. The same value also returns to the AND plane as feedback.

Configuration pins choose the storage type, the clock source, the polarity, the output path, which neighbour terms are borrowed and which native terms are lent away. The storage element is timed by rising edges of a chosen clock source: either a product term or a dedicated clock pin. Both sources are sampled on the system clock. Preset and clear come from product terms, and clear may be the OR of two terms. A processor can write the register through a load strobe and one data bit, and it can read the register through one data bit. Every pin is a plain level or strobe with no handshake, because the cell never stalls and needs no back-pressure.

Top module: `pld_out_cell`

## Requirements
- R1: The sum is the OR of every native term whose lend bit is clear, together with every borrowed input term whose borrow bit is set. Other terms have no effect on the sum.
- R2: When `cfg_invert` is 1, the sum is inverted before it is used anywhere. When `cfg_invert` is 0, the sum passes unchanged.
- R3: When `cfg_use_reg` is 0, `pin_out` follows the polarity-adjusted sum in the same cycle. When `cfg_use_reg` is 1, `pin_out` shows the register. `fb_out` always equals `pin_out`.
- R4: In mode 0 (D), a clock event loads the sum into the register.
- R5: In mode 1 (toggle), a clock event inverts the register when the sum is 1 and leaves it unchanged when the sum is 0.
- R6: In mode 2 (JK), J is the sum and K is the OR of `pt_second`. On a clock event, 10 sets the register, 01 clears it, 11 inverts it and 00 holds it.
- R7: In mode 3 (SR), S is the sum and R is the OR of `pt_second`. On a clock event, S alone sets the register, R alone clears it, and both or neither hold it.
- R8: `cfg_clk_pin`=1 selects `clk_pin` as the clock source and 0 selects `pt_clk`. A clock event is a rising edge of the selected source as sampled on `clk`, and the register changes at that same `clk` edge. The source that is not selected has no effect, and without an event the register holds.
- R9: `pt_pre` and any bit of `pt_clr` act on `cpu_rdata` and on the register path of the pin in the same cycle. While either is high it is stored at each `clk` edge. Clear wins over preset, and both win over a load and over a clock event.
- R10: `cpu_load` writes `cpu_wdata` into the register at the next `clk` edge and wins over a clock event. `cpu_rdata` always shows the register state.
- R11: `lend_out` equals `pt_native` masked by `cfg_lend_en`.
- R12: While `rst_n` is low, the register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pt_native | input | NATIVE_PT | Native product terms |
| pt_borrow_in | input | BORROW_PT | Terms offered by neighbouring cells |
| pt_second | input | SECOND_PT | Terms forming K or R |
| pt_clk | input | 1 | Product-term clock source |
| clk_pin | input | 1 | Dedicated clock source |
| pt_pre | input | 1 | Preset term, active high |
| pt_clr | input | CLR_PT | Clear terms, ORed, active high |
| cfg_mode | input | 2 | Storage type: 0 D, 1 toggle, 2 JK, 3 SR |
| cfg_clk_pin | input | 1 | 1 selects clk_pin, 0 selects pt_clk |
| cfg_invert | input | 1 | Invert the sum |
| cfg_use_reg | input | 1 | 1 register path, 0 combinational path |
| cfg_borrow_en | input | BORROW_PT | Per-term borrow enables |
| cfg_lend_en | input | NATIVE_PT | Per-term lend enables |
| cpu_load | input | 1 | Processor write strobe |
| cpu_wdata | input | 1 | Processor write bit |
| cpu_rdata | output | 1 | Register state for processor reads |
| pin_out | output | 1 | Cell output to the pin |
| fb_out | output | 1 | Feedback to the AND plane |
| lend_out | output | NATIVE_PT | Native terms lent to neighbours |

## Verification
The bench drives events that compete for the register in the same cycle. It raises preset and clear together and checks that clear wins both at once and after the next edge. It asserts a processor load in the same cycle as a rising clock source while the D input holds the opposite value, and checks that the loaded bit is what remains. It also asserts a preset together with a load and checks that preset wins.

// File: rtl/pld_oc_pkg.sv
`timescale 1ns/1ps
package pld_oc_pkg;
  typedef enum logic [1:0] {FF_D = 2'd0, FF_T = 2'd1, FF_JK = 2'd2, FF_SR = 2'd3} ff_mode_e;

  function automatic logic ff_next(input ff_mode_e mode, input logic q,
                                   input logic a, input logic b);
    logic n;
    unique case (mode)
      FF_D:    n = a;
      FF_T:    n = q ^ a;
      FF_JK:   n = (a & ~b) | (~b & q) | (a & ~q);
      FF_SR:   n = (a & ~b) | (q & ~(b & ~a));
      default: n = q;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/pld_term_sum.sv
`timescale 1ns/1ps
module pld_term_sum #(
  parameter int NATIVE_PT = 4,
  parameter int BORROW_PT = 2,
  parameter int SECOND_PT = 2
) (
  input  logic [NATIVE_PT-1:0] pt_native,
  input  logic [BORROW_PT-1:0] pt_borrow_in,
  input  logic [SECOND_PT-1:0] pt_second,
  input  logic [BORROW_PT-1:0] cfg_borrow_en,
  input  logic [NATIVE_PT-1:0] cfg_lend_en,
  input  logic                 cfg_invert,
  output logic                 sum_pol,
  output logic                 second_sum,
  output logic [NATIVE_PT-1:0] lend_out
);
  logic [NATIVE_PT-1:0] kept;
  logic [BORROW_PT-1:0] taken;

  for (genvar n = 0; n < NATIVE_PT; n++) begin : g_native
    assign kept[n]     = pt_native[n] & ~cfg_lend_en[n];
    assign lend_out[n] = pt_native[n] &  cfg_lend_en[n];
  end

  for (genvar b = 0; b < BORROW_PT; b++) begin : g_borrow
    assign taken[b] = pt_borrow_in[b] & cfg_borrow_en[b];
  end

  assign sum_pol    = (|kept | |taken) ^ cfg_invert;
  assign second_sum = |pt_second;
endmodule

// File: rtl/pld_clk_pick.sv
`timescale 1ns/1ps
module pld_clk_pick (
  input  logic clk,
  input  logic rst_n,
  input  logic use_pin,
  input  logic clk_pin,
  input  logic pt_clk,
  output logic clk_event
);
  logic src, src_q;

  assign src = use_pin ? clk_pin : pt_clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= 1'b1;
    else        src_q <= src;
  end

  assign clk_event = src & ~src_q;
endmodule

// File: rtl/pld_state_elem.sv
`timescale 1ns/1ps
module pld_state_elem
  import pld_oc_pkg::*;
#(
  parameter int CLR_PT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ff_mode_e          mode,
  input  logic              in_a,
  input  logic              in_b,
  input  logic              clk_event,
  input  logic              pre,
  input  logic [CLR_PT-1:0] clr_terms,
  input  logic              load,
  input  logic              wdata,
  output logic              q_eff
);
  logic q_reg, clr;

  assign clr = |clr_terms;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         q_reg <= 1'b0;
    else if (clr)       q_reg <= 1'b0;
    else if (pre)       q_reg <= 1'b1;
    else if (load)      q_reg <= wdata;
    else if (clk_event) q_reg <= ff_next(mode, q_reg, in_a, in_b);
  end

  always_comb begin
    if (clr)      q_eff = 1'b0;
    else if (pre) q_eff = 1'b1;
    else          q_eff = q_reg;
  end
endmodule

// File: rtl/pld_out_cell.sv
`timescale 1ns/1ps
module pld_out_cell
  import pld_oc_pkg::*;
#(
  parameter int NATIVE_PT = 4,
  parameter int BORROW_PT = 2,
  parameter int SECOND_PT = 2,
  parameter int CLR_PT    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NATIVE_PT-1:0] pt_native,
  input  logic [BORROW_PT-1:0] pt_borrow_in,
  input  logic [SECOND_PT-1:0] pt_second,
  input  logic                 pt_clk,
  input  logic                 clk_pin,
  input  logic                 pt_pre,
  input  logic [CLR_PT-1:0]    pt_clr,
  input  logic [1:0]           cfg_mode,
  input  logic                 cfg_clk_pin,
  input  logic                 cfg_invert,
  input  logic                 cfg_use_reg,
  input  logic [BORROW_PT-1:0] cfg_borrow_en,
  input  logic [NATIVE_PT-1:0] cfg_lend_en,
  input  logic                 cpu_load,
  input  logic                 cpu_wdata,
  output logic                 cpu_rdata,
  output logic                 pin_out,
  output logic                 fb_out,
  output logic [NATIVE_PT-1:0] lend_out
);
  logic sum_pol, second_sum, clk_event, q_eff;

  pld_term_sum #(
    .NATIVE_PT(NATIVE_PT), .BORROW_PT(BORROW_PT), .SECOND_PT(SECOND_PT)
  ) u_sum (
    .pt_native(pt_native), .pt_borrow_in(pt_borrow_in), .pt_second(pt_second),
    .cfg_borrow_en(cfg_borrow_en), .cfg_lend_en(cfg_lend_en),
    .cfg_invert(cfg_invert), .sum_pol(sum_pol), .second_sum(second_sum),
    .lend_out(lend_out)
  );

  pld_clk_pick u_clk (
    .clk(clk), .rst_n(rst_n), .use_pin(cfg_clk_pin), .clk_pin(clk_pin),
    .pt_clk(pt_clk), .clk_event(clk_event)
  );

  pld_state_elem #(.CLR_PT(CLR_PT)) u_ff (
    .clk(clk), .rst_n(rst_n), .mode(ff_mode_e'(cfg_mode)), .in_a(sum_pol),
    .in_b(second_sum), .clk_event(clk_event), .pre(pt_pre), .clr_terms(pt_clr),
    .load(cpu_load), .wdata(cpu_wdata), .q_eff(q_eff)
  );

  assign cpu_rdata = q_eff;
  assign pin_out   = cfg_use_reg ? q_eff : sum_pol;
  assign fb_out    = pin_out;
endmodule

// File: rtl/pld_out_cell_chk.sv
`timescale 1ns/1ps
module pld_out_cell_chk #(
  parameter int CLR_PT = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pt_clk,
  input logic              clk_pin,
  input logic              pt_pre,
  input logic [CLR_PT-1:0] pt_clr,
  input logic              cfg_clk_pin,
  input logic              cfg_use_reg,
  input logic              cpu_load,
  input logic              cpu_wdata,
  input logic              cpu_rdata,
  input logic              pin_out
);
  logic src_now;
  assign src_now = cfg_clk_pin ? clk_pin : pt_clk;

  // R9
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pt_clr) |-> !cpu_rdata);

  // R9
  preset_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pt_pre && !(|pt_clr)) |-> cpu_rdata);

  // R10
  load_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_load && !pt_pre && !(|pt_clr)) |=>
      (pt_pre || (|pt_clr) || cpu_rdata == $past(cpu_wdata)));

  // R8
  hold_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_load && !pt_pre && !(|pt_clr) && !src_now) |=>
      (pt_pre || (|pt_clr) || cpu_rdata == $past(cpu_rdata)));

  // R3
  reg_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_use_reg |-> (pin_out == cpu_rdata));
endmodule

bind pld_out_cell pld_out_cell_chk #(.CLR_PT(CLR_PT)) u_chk (
  .clk(clk), .rst_n(rst_n), .pt_clk(pt_clk), .clk_pin(clk_pin),
  .pt_pre(pt_pre), .pt_clr(pt_clr), .cfg_clk_pin(cfg_clk_pin),
  .cfg_use_reg(cfg_use_reg), .cpu_load(cpu_load), .cpu_wdata(cpu_wdata),
  .cpu_rdata(cpu_rdata), .pin_out(pin_out)
);

// File: tb/pld_out_cell_bench.sv
`timescale 1ns/1ps
module pld_out_cell_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] pt_native;
  logic [1:0] pt_borrow_in, pt_second, pt_clr, cfg_mode, cfg_borrow_en;
  logic       pt_clk, clk_pin, pt_pre, cfg_clk_pin, cfg_invert, cfg_use_reg;
  logic [3:0] cfg_lend_en;
  logic       cpu_load, cpu_wdata, cpu_rdata, pin_out, fb_out;
  logic [3:0] lend_out;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  pld_out_cell u_pld_out_cell (
    .clk(clk), .rst_n(rst_n), .pt_native(pt_native), .pt_borrow_in(pt_borrow_in),
    .pt_second(pt_second), .pt_clk(pt_clk), .clk_pin(clk_pin), .pt_pre(pt_pre),
    .pt_clr(pt_clr), .cfg_mode(cfg_mode), .cfg_clk_pin(cfg_clk_pin),
    .cfg_invert(cfg_invert), .cfg_use_reg(cfg_use_reg),
    .cfg_borrow_en(cfg_borrow_en), .cfg_lend_en(cfg_lend_en),
    .cpu_load(cpu_load), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .pin_out(pin_out), .fb_out(fb_out), .lend_out(lend_out)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse(input logic use_pin);
    if (use_pin) clk_pin = 1'b1; else pt_clk = 1'b1;
    tick();
    clk_pin = 1'b0; pt_clk = 1'b0;
    tick();
  endtask

  task automatic set_q(input logic v);
    cpu_load = 1'b1; cpu_wdata = v; tick(); cpu_load = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pt_native = '0; pt_borrow_in = '0; pt_second = '0; pt_clr = '0;
    pt_clk = 0; clk_pin = 0; pt_pre = 0; cfg_mode = 2'd0; cfg_clk_pin = 1;
    cfg_invert = 0; cfg_use_reg = 1; cfg_borrow_en = '0; cfg_lend_en = '0;
    cpu_load = 0; cpu_wdata = 0;
    tick(); tick();
    chk("R12 reset rdata", {3'b0, cpu_rdata}, 4'h0);
    chk("R12 reset pin", {3'b0, pin_out}, 4'h0);
    rst_n = 1'b1; tick();
  endtask

  task automatic t_comb();
    cfg_use_reg = 0; pt_native = 4'b0100; #1;
    chk("R1 native term", {3'b0, pin_out}, 4'h1);
    chk("R3 feedback", {3'b0, fb_out}, {3'b0, pin_out});
    cfg_invert = 1; #1;
    chk("R2 inverted", {3'b0, pin_out}, 4'h0);
    cfg_invert = 0; pt_native = 0; pt_borrow_in = 2'b01; #1;
    chk("R1 borrow disabled", {3'b0, pin_out}, 4'h0);
    cfg_borrow_en = 2'b01; #1;
    chk("R1 borrow enabled", {3'b0, pin_out}, 4'h1);
    pt_borrow_in = 0; cfg_borrow_en = 0; pt_native = 4'b0001; cfg_lend_en = 4'b0001; #1;
    chk("R11 lent term ignored", {3'b0, pin_out}, 4'h0);
    chk("R11 lend_out", lend_out, 4'b0001);
    cfg_invert = 1; #1;
    chk("R2 inverted zero", {3'b0, fb_out}, 4'h1);
    cfg_invert = 0; cfg_lend_en = 0; pt_native = 0; cfg_use_reg = 1;
  endtask

  task automatic t_dmode();
    cfg_mode = 2'd0; cfg_clk_pin = 1; set_q(0);
    pt_native = 4'b0010; tick(); tick();
    chk("R8 hold without event", {3'b0, pin_out}, 4'h0);
    pulse(1);
    chk("R4 D loads 1", {3'b0, pin_out}, 4'h1);
    pt_native = 0; pulse(1);
    chk("R4 D loads 0", {3'b0, cpu_rdata}, 4'h0);
  endtask

  task automatic t_tmode();
    cfg_mode = 2'd1; set_q(0); pt_native = 4'b1000;
    pulse(1); chk("R5 toggle up", {3'b0, cpu_rdata}, 4'h1);
    pulse(1); chk("R5 toggle down", {3'b0, cpu_rdata}, 4'h0);
    pt_native = 0; pulse(1); chk("R5 no toggle", {3'b0, cpu_rdata}, 4'h0);
  endtask

  task automatic t_jk();
    cfg_mode = 2'd2; set_q(0);
    pt_native = 4'b0001; pt_second = 0;     pulse(1); chk("R6 J set", {3'b0, cpu_rdata}, 4'h1);
    pt_native = 0;       pt_second = 0;     pulse(1); chk("R6 hold", {3'b0, cpu_rdata}, 4'h1);
    pt_native = 4'b0001; pt_second = 2'b10; pulse(1); chk("R6 toggle 1", {3'b0, cpu_rdata}, 4'h0);
    pt_native = 0;       pt_second = 2'b01; pulse(1); chk("R6 K clear", {3'b0, cpu_rdata}, 4'h0);
    pt_native = 4'b0001; pt_second = 2'b01; pulse(1); chk("R6 toggle 0", {3'b0, cpu_rdata}, 4'h1);
    pt_native = 0; pt_second = 0;
  endtask

  task automatic t_sr();
    cfg_mode = 2'd3; set_q(0);
    pt_native = 4'b0001; pt_second = 0;     pulse(1); chk("R7 S set", {3'b0, cpu_rdata}, 4'h1);
    pt_second = 2'b01;                      pulse(1); chk("R7 both hold 1", {3'b0, cpu_rdata}, 4'h1);
    pt_native = 0;                          pulse(1); chk("R7 R clear", {3'b0, cpu_rdata}, 4'h0);
    pt_native = 4'b0001;                    pulse(1); chk("R7 both hold 0", {3'b0, cpu_rdata}, 4'h0);
    pt_native = 0; pt_second = 0;
  endtask

  task automatic t_clksrc();
    cfg_mode = 2'd0; set_q(0); cfg_clk_pin = 0; pt_native = 4'b0001;
    pulse(1); chk("R8 unselected pin ignored", {3'b0, cpu_rdata}, 4'h0);
    pulse(0); chk("R8 product-term clock", {3'b0, cpu_rdata}, 4'h1);
    cfg_clk_pin = 1; pt_native = 0;
    pulse(0); chk("R8 unselected term ignored", {3'b0, cpu_rdata}, 4'h1);
    pulse(1); chk("R8 pin clock", {3'b0, cpu_rdata}, 4'h0);
  endtask

  task automatic t_prio();
    set_q(0); pt_pre = 1; #1;
    chk("R9 preset immediate", {3'b0, pin_out}, 4'h1);
    pt_clr = 2'b10; #1;
    chk("R9 clear beats preset", {3'b0, cpu_rdata}, 4'h0);
    tick(); pt_pre = 0; pt_clr = 0; #1;
    chk("R9 clear stored", {3'b0, cpu_rdata}, 4'h0);
    set_q(1); pt_clr = 2'b01; tick(); pt_clr = 0; #1;
    chk("R9 second clear term", {3'b0, cpu_rdata}, 4'h0);
    cpu_load = 1; cpu_wdata = 0; pt_pre = 1; tick(); cpu_load = 0; pt_pre = 0; #1;
    chk("R9 preset beats load", {3'b0, cpu_rdata}, 4'h1);
  endtask

  task automatic t_load();
    cfg_mode = 2'd0; cfg_clk_pin = 1;
    set_q(1); chk("R10 load 1", {3'b0, cpu_rdata}, 4'h1);
    set_q(0); chk("R10 load 0", {3'b0, cpu_rdata}, 4'h0);
    set_q(1); pt_native = 4'b0001;
    cpu_load = 1; cpu_wdata = 0; clk_pin = 1; tick();
    cpu_load = 0; clk_pin = 0; tick();
    chk("R10 load beats clock event", {3'b0, cpu_rdata}, 4'h0);
    pt_native = 0;
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_comb();
    t_dmode();
    t_tmode();
    t_jk();
    t_sr();
    t_clksrc();
    t_prio();
    t_load();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule